// File: doc/BRIEF.md
# Code Cache Line Valid Tracker

This block keeps the bookkeeping for a small on-chip instruction cache of 512 bytes. The cache is split into 32 lines of 16 bytes. The block does not hold the cache data. It holds a 16-bit base address, one valid flag per line and an active bit. The host fills the cache RAM by byte writes at cache-relative offsets. The block watches those writes and marks a line valid once the byte at the top of that line has been written.

The base address is loaded in two byte steps. The low byte is written first and is held in a staging register. The high byte is written second; that write commits the full base and turns the cache on. The low four bits of the base are always forced to zero.

A program-counter lookup port reports, combinationally, two things: whether the PC falls inside the active 512-byte window, and whether the line it lands in is valid. A flush strobe empties the cache state.

Top module: `code_cache_tracker`

## Requirements
- R1: After reset, all 32 line flags are 0, the base is 0x0000, the active bit is 0, and both lookup outputs are 0.
- R2: A host write updates the line flags on the next clock edge. When the offset's low four bits are 0xF, the flag of line offset[8:4] is set to 1. Any other offset leaves every flag unchanged.
- R3: A write of the low base byte changes neither the visible base nor the active bit. A following write of the high byte loads base = {high byte, low byte with bits [3:0] cleared} and sets active, both on the next clock edge. Base bits [3:0] are always 0.
- R4: A flush clears all line flags, the base, the staged low byte and the active bit on the next clock edge.
- R5: When a flush arrives in the same cycle as a host write or a base-byte write, the flush wins: the state after the edge is the flushed state.
- R6: `pc_hit` is 1 exactly when active is 1 and base <= PC < base + 512. It is 0 whenever the cache is inactive.
- R7: `pc_line_valid` is 1 exactly when `pc_hit` is 1 and the flag of line ((PC - base) >> 4) mod 32 is 1.
- R8: The upper bound base + 512 is computed without 16-bit wraparound. When the window runs past 0xFFFF, PCs from base up to 0xFFFF hit, and low PCs such as 0x0050 do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host byte write into cache RAM |
| host_wr_ofs | input | 9 | Cache-relative byte offset of the write |
| base_wr_lo | input | 1 | Write low byte of base |
| base_wr_hi | input | 1 | Write high byte of base, commit and activate |
| base_wr_byte | input | 8 | Byte value for a base write |
| flush | input | 1 | Clear all cache tracking state |
| pc | input | 16 | Program counter to look up |
| base_addr | output | 16 | Committed base address |
| cache_active | output | 1 | Cache active bit |
| line_valid | output | 32 | Per-line valid flags |
| pc_hit | output | 1 | PC falls in the active window |
| pc_line_valid | output | 1 | PC hits and its line is valid |

## Verification
Every state change (flags, base, active) appears one clock edge after the strobe that causes it. Lookup outputs follow the current state and the PC with no register delay.

The driver applies each stimulus, together with the PC to probe, at the falling edge. It pushes the expected post-edge state and lookup result into a queue. The monitor pops that entry a quarter period after the next rising edge, while the PC is still held. This way the registered state and the combinational lookup are compared in the one cycle where both are due.

// File: rtl/cct_pkg.sv
package cct_pkg;
   localparam int unsigned DEF_ADDR_W = 16;
   localparam int unsigned DEF_OFS_W  = 4;
   localparam int unsigned DEF_IDX_W  = 5;

   typedef struct packed {
      logic hit;
      logic line_ok;
   } lookup_t;
endpackage

// File: rtl/cct_base_reg.sv
module cct_base_reg #(
   parameter int unsigned ADDR_W = cct_pkg::DEF_ADDR_W,
   parameter int unsigned OFS_W  = cct_pkg::DEF_OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [ADDR_W/2-1:0] wr_byte,
   input  logic              flush,
   output logic [ADDR_W-1:0] base,
   output logic              active
);
   localparam int unsigned HALF_W = ADDR_W / 2;

   generate
      if ((ADDR_W % 2) != 0) begin : g_bad_width
         $error("ADDR_W must be even");
      end
   endgenerate

   logic [HALF_W-1:0] lo_stage_q;
   logic [ADDR_W-1:0] base_q;
   logic              active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_stage_q <= '0;
         base_q     <= '0;
         active_q   <= 1'b0;
      end else if (flush) begin
         lo_stage_q <= '0;
         base_q     <= '0;
         active_q   <= 1'b0;
      end else begin
         if (wr_lo) lo_stage_q <= wr_byte;
         if (wr_hi) begin
            base_q   <= {wr_byte, lo_stage_q[HALF_W-1:OFS_W], {OFS_W{1'b0}}};
            active_q <= 1'b1;
         end
      end
   end

   assign base   = base_q;
   assign active = active_q;

   a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      base[OFS_W-1:0] == '0);
   a_r3_hi_activates: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !flush) |=> active);
   a_r3_lo_invisible: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi && !flush) |=> ($stable(base) && $stable(active)));
   a_r4_flush_base: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!active && base == '0));
endmodule

// File: rtl/cct_valid_flags.sv
module cct_valid_flags #(
   parameter int unsigned OFS_W = cct_pkg::DEF_OFS_W,
   parameter int unsigned IDX_W = cct_pkg::DEF_IDX_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [OFS_W+IDX_W-1:0] wr_ofs,
   input  logic                   flush,
   output logic [(1<<IDX_W)-1:0]  flags
);
   localparam int unsigned LINES = 1 << IDX_W;
   localparam int unsigned WIN_W = OFS_W + IDX_W;

   logic [LINES-1:0] flags_q;
   logic [LINES-1:0] flags_d;
   logic             last_byte;

   assign last_byte = wr_en && (wr_ofs[OFS_W-1:0] == {OFS_W{1'b1}});

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         always_comb begin
            if (flush)
               flags_d[i] = 1'b0;
            else
               flags_d[i] = flags_q[i] ||
                            (last_byte && (wr_ofs[WIN_W-1:OFS_W] == IDX_W'(i)));
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign flags = flags_q;

   a_r2_mid_line_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush && wr_ofs[OFS_W-1:0] != {OFS_W{1'b1}}) |=> $stable(flags));
   a_r2_last_byte_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush && wr_ofs[OFS_W-1:0] == {OFS_W{1'b1}})
      |=> flags[$past(wr_ofs[WIN_W-1:OFS_W])]);
   a_r4_flush_flags: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (flags == '0));
endmodule

// File: rtl/cct_lookup.sv
module cct_lookup #(
   parameter int unsigned ADDR_W = cct_pkg::DEF_ADDR_W,
   parameter int unsigned OFS_W  = cct_pkg::DEF_OFS_W,
   parameter int unsigned IDX_W  = cct_pkg::DEF_IDX_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     pc,
   input  logic [ADDR_W-1:0]     base,
   input  logic                  active,
   input  logic [(1<<IDX_W)-1:0] flags,
   output cct_pkg::lookup_t      result
);
   localparam int unsigned WIN_W     = OFS_W + IDX_W;
   localparam int unsigned WIN_BYTES = 1 << WIN_W;

   generate
      if (ADDR_W <= WIN_W) begin : g_bad_window
         $error("address must be wider than the cache window");
      end
   endgenerate

   logic [ADDR_W:0]   limit;
   logic [ADDR_W-1:0] delta;
   logic [IDX_W-1:0]  line_idx;
   logic              in_win;

   assign limit    = {1'b0, base} + (ADDR_W+1)'(WIN_BYTES);
   assign delta    = pc - base;
   assign line_idx = delta[WIN_W-1:OFS_W];
   assign in_win   = (pc >= base) && ({1'b0, pc} < limit);

   assign result.hit     = active && in_win;
   assign result.line_ok = active && in_win && flags[line_idx];

   a_r6_inactive_miss: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !result.hit);
   a_r7_valid_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      result.line_ok |-> result.hit);
endmodule

// File: rtl/code_cache_tracker.sv
module code_cache_tracker #(
   parameter int unsigned ADDR_W = cct_pkg::DEF_ADDR_W,
   parameter int unsigned OFS_W  = cct_pkg::DEF_OFS_W,
   parameter int unsigned IDX_W  = cct_pkg::DEF_IDX_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   host_wr_en,
   input  logic [OFS_W+IDX_W-1:0] host_wr_ofs,
   input  logic                   base_wr_lo,
   input  logic                   base_wr_hi,
   input  logic [ADDR_W/2-1:0]    base_wr_byte,
   input  logic                   flush,
   input  logic [ADDR_W-1:0]      pc,
   output logic [ADDR_W-1:0]      base_addr,
   output logic                   cache_active,
   output logic [(1<<IDX_W)-1:0]  line_valid,
   output logic                   pc_hit,
   output logic                   pc_line_valid
);
   cct_pkg::lookup_t look;

   cct_base_reg #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) base_i (
      .clk(clk), .rst_n(rst_n), .wr_lo(base_wr_lo), .wr_hi(base_wr_hi),
      .wr_byte(base_wr_byte), .flush(flush), .base(base_addr),
      .active(cache_active));

   cct_valid_flags #(.OFS_W(OFS_W), .IDX_W(IDX_W)) flags_i (
      .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .wr_ofs(host_wr_ofs),
      .flush(flush), .flags(line_valid));

   cct_lookup #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) look_i (
      .clk(clk), .rst_n(rst_n), .pc(pc), .base(base_addr),
      .active(cache_active), .flags(line_valid), .result(look));

   assign pc_hit        = look.hit;
   assign pc_line_valid = look.line_ok;

   a_r5_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && (host_wr_en || base_wr_hi)) |=> (line_valid == '0 && !cache_active));
endmodule

// File: tb/code_cache_tracker_tb_top.sv
module code_cache_tracker_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [8:0]  host_wr_ofs = '0;
   logic        base_wr_lo = 1'b0;
   logic        base_wr_hi = 1'b0;
   logic [7:0]  base_wr_byte = '0;
   logic        flush = 1'b0;
   logic [15:0] pc = '0;
   logic [15:0] base_addr;
   logic        cache_active;
   logic [31:0] line_valid;
   logic        pc_hit;
   logic        pc_line_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      string       tag;
      logic [15:0] base;
      logic        act;
      logic [31:0] flags;
      logic        hit;
      logic        lv;
   } exp_t;

   exp_t sb_q[$];

   logic [15:0] m_base = '0;
   logic        m_act = 1'b0;
   logic [31:0] m_flags = '0;
   logic [7:0]  m_lo = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   code_cache_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_ofs(host_wr_ofs),
      .base_wr_lo(base_wr_lo), .base_wr_hi(base_wr_hi), .base_wr_byte(base_wr_byte),
      .flush(flush), .pc(pc), .base_addr(base_addr), .cache_active(cache_active),
      .line_valid(line_valid), .pc_hit(pc_hit), .pc_line_valid(pc_line_valid));

   task automatic step(input string tag, input bit we, input logic [8:0] ofs,
                       input bit lo, input bit hi, input logic [7:0] b,
                       input bit fl, input logic [15:0] p);
      exp_t e;
      logic [16:0] lim;
      logic [15:0] d;
      @(negedge clk);
      host_wr_en = we; host_wr_ofs = ofs; base_wr_lo = lo; base_wr_hi = hi;
      base_wr_byte = b; flush = fl; pc = p;
      if (fl) begin
         m_flags = '0; m_base = '0; m_act = 1'b0; m_lo = '0;
      end else begin
         if (we && ofs[3:0] == 4'hF) m_flags[ofs[8:4]] = 1'b1;
         if (hi) begin
            m_base = {b, m_lo[7:4], 4'h0};
            m_act = 1'b1;
         end
         if (lo) m_lo = b;
      end
      lim = {1'b0, m_base} + 17'd512;
      d = p - m_base;
      e.tag = tag; e.base = m_base; e.act = m_act; e.flags = m_flags;
      e.hit = m_act && (p >= m_base) && ({1'b0, p} < lim);
      e.lv = e.hit && m_flags[d[8:4]];
      sb_q.push_back(e);
   endtask

   task automatic probe(input string tag, input logic [15:0] p);
      step(tag, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, p);
   endtask

   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (base_addr !== e.base || cache_active !== e.act || line_valid !== e.flags ||
             pc_hit !== e.hit || pc_line_valid !== e.lv) begin
            errors++;
            $display("FAIL %s: got base=%h act=%b flags=%h hit=%b lv=%b exp base=%h act=%b flags=%h hit=%b lv=%b",
                     e.tag, base_addr, cache_active, line_valid, pc_hit, pc_line_valid,
                     e.base, e.act, e.flags, e.hit, e.lv);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      probe("R1 reset state", 16'h0000);
      step("R2 mid-line write ignored", 1'b1, 9'h013, 0, 0, 0, 0, 16'h0000);
      step("R2 last byte line1", 1'b1, 9'h01F, 0, 0, 0, 0, 16'h0000);
      step("R2 last byte line31", 1'b1, 9'h1FF, 0, 0, 0, 0, 16'h0000);
      step("R2 line0 offset 0", 1'b1, 9'h000, 0, 0, 0, 0, 16'h0000);
      step("R3 low byte hidden", 1'b0, '0, 1, 0, 8'h37, 0, 16'h1240);
      step("R3 high byte commit", 1'b0, '0, 0, 1, 8'h12, 0, 16'h1240);
      probe("R6 below base", 16'h122F);
      probe("R7 last line valid", 16'h142F);
      probe("R6 past window end", 16'h1430);
      probe("R7 hit invalid line", 16'h1250);
      probe("R7 base line0 invalid", 16'h1230);
      step("R5 flush beats write and base", 1'b1, 9'h02F, 0, 1, 8'h40, 1, 16'h4000);
      step("R2 refill line2", 1'b1, 9'h02F, 0, 0, 0, 0, 16'h0000);
      step("R3 low byte 0x0F", 1'b0, '0, 1, 0, 8'h0F, 0, 16'h0000);
      step("R3 high byte low bits cleared", 1'b0, '0, 0, 1, 8'h00, 0, 16'h0020);
      probe("R6 top of window", 16'h01FF);
      step("R4 flush", 1'b0, '0, 0, 0, 0, 1, 16'h0020);
      step("R3 low byte 0x00", 1'b0, '0, 1, 0, 8'h00, 0, 16'h0000);
      step("R8 base near top", 1'b0, '0, 0, 1, 8'hFF, 0, 16'hFFFF);
      step("R8 write line15", 1'b1, 9'h0FF, 0, 0, 0, 0, 16'hFFF0);
      probe("R8 wrapped pc misses", 16'h0050);
      probe("R8 base itself hits", 16'hFF00);
      probe("R6 idle", 16'h0000);
      @(negedge clk); @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule